// File: doc/BRIEF.md
# System Coprocessor Status/Cause Controller

This block is the system-control register file that sits beside a MIPS-style integer core. It keeps the processor Status word (index 12), the Cause word (index 13), the exception program counter (index 14), and a general array for every other index. The core moves words in and out through one write port and one read port. Three other operations are built in: a return-from-exception pop of the interrupt/mode stack, a syscall trap, and a software-interrupt check.

The core reports the address of the current instruction and whether that instruction sits in a branch delay slot. When an exception is taken, the block pushes the mode stack in Status, records the exception code and the delay-slot flag in Cause, and loads EPC. One cycle later it pulses an exception request toward the fetch logic, carrying the code and the delay flag. A software interrupt is looked for only in the cycle that writes Status or Cause. The check uses the values that the write has just produced.

Top module: `sysctrl_regs`

## Requirements
- R1: After reset, Status, Cause and EPC read as zero and the exception request output is low.
- R2: A write to any index other than 12, 13 or 14 stores the whole 32-bit word. A read returns its data one clock after rd_en; index 14 reads and writes EPC.
- R3: A write to Cause (index 13) can change only Cause bits 9:8. Every other Cause bit keeps its value.
- R4: A write to Status or to Cause takes a software interrupt when (Cause AND Status AND 0x300) is non-zero and Status bit 0 is 1, using the post-write values. The request is then high in the next cycle with code 0, and Cause bits 6:2 read as 0.
- R5: The software-interrupt check runs only on writes to index 12 or 13. A return-from-exception that enables a pending interrupt raises no request.
- R6: Return-from-exception sets Status bits 3:0 to the old bits 5:2 and keeps bits 31:4.
- R7: A syscall raises a request with code 8 in the next cycle, sets Cause bits 6:2 to 8 (low byte 0x20) and loads EPC with the syscall's own address.
- R8: Every exception copies the core's delay-slot flag to the exc_in_delay output and to Cause bit 31.
- R9: On exception entry, Status bits 5:0 move left by two, bits 1:0 become 0 and bits 31:6 are kept.
- R10: A read and a write to the same index in the same cycle return the value from before the write.
- R11: In one cycle a syscall overrides a register write, and a register write overrides return-from-exception. The overridden operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 5 | Register index to read |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| rfe_req | input | 1 | Return-from-exception operation |
| sys_req | input | 1 | Syscall operation |
| instr_pc | input | 32 | Address of the current instruction |
| in_delay | input | 1 | Current instruction is in a branch delay slot |
| exc_req | output | 1 | Exception request, one-cycle pulse |
| exc_code | output | 5 | Exception code of the latest request |
| exc_in_delay | output | 1 | Delay-slot flag of the latest request |

## Verification
The bound checker runs on every cycle. It covers the Cause write mask, the stack pop on return-from-exception, the stack push and EPC load on a syscall, the state that every software-interrupt request leaves behind, agreement between Cause bit 31 and the delay output, and that no request appears without a write or a syscall in the cycle before it. Other cases need directed sequences in the bench, because the outcome depends on earlier history. These are: a return-from-exception that must not trigger a pending interrupt, a Cause write that raises an interrupt only because Status was set up earlier, read-first ordering on the same index, and which operation wins when several arrive in one cycle.

// File: rtl/sysctrl_pkg.sv
package sysctrl_pkg;
  localparam int IDX_STATUS = 12;
  localparam int IDX_CAUSE  = 13;
  localparam int IDX_EPC    = 14;
  localparam logic [4:0] CODE_INTR    = 5'd0;
  localparam logic [4:0] CODE_SYSCALL = 5'd8;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_CAUSE  = 2'd2,
    SRC_EPC    = 2'd3
  } rd_src_e;

  // mode stack push on exception entry: bits 5:0 move up by two
  function automatic logic [31:0] stack_push(input logic [31:0] s);
    return {s[31:6], s[3:0], 2'b00};
  endfunction

  // mode stack pop on return-from-exception
  function automatic logic [31:0] stack_pop(input logic [31:0] s);
    return {s[31:4], s[5:2]};
  endfunction
endpackage

// File: rtl/sc_reg_bank.sv
module sc_reg_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single-clock RAM, maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sc_status_unit.sv
module sc_status_unit
  import sysctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stat,
  input  logic [31:0] wr_data,
  input  logic        rfe_do,
  input  logic        exc_take,
  output logic [31:0] status_q,
  output logic [31:0] status_base
);
  always_comb begin
    if (wr_stat)     status_base = wr_data;
    else if (rfe_do) status_base = stack_pop(status_q);
    else             status_base = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           status_q <= '0;
    else if (exc_take) status_q <= stack_push(status_base);
    else               status_q <= status_base;
  end
endmodule

// File: rtl/sc_cause_unit.sv
module sc_cause_unit
  import sysctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_cause,
  input  logic        wr_epc,
  input  logic [31:0] wr_data,
  input  logic        sys_do,
  input  logic        sw_take,
  input  logic        in_delay,
  input  logic [31:0] instr_pc,
  output logic [31:0] cause_q,
  output logic [31:0] cause_base,
  output logic [31:0] epc_q
);
  logic [31:0] cause_nxt;

  // software can reach only the two software-interrupt bits
  always_comb begin
    cause_base = cause_q;
    if (wr_cause) cause_base[9:8] = wr_data[9:8];
  end

  always_comb begin
    cause_nxt = cause_base;
    if (sys_do || sw_take) begin
      cause_nxt[6:2] = sys_do ? CODE_SYSCALL : CODE_INTR;
      cause_nxt[31]  = in_delay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else begin
      cause_q <= cause_nxt;
      if (sys_do || sw_take) epc_q <= instr_pc;
      else if (wr_epc)       epc_q <= wr_data;
    end
  end
endmodule

// File: rtl/sysctrl_regs.sv
module sysctrl_regs
  import sysctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rfe_req,
  input  logic              sys_req,
  input  logic [DATA_W-1:0] instr_pc,
  input  logic              in_delay,
  output logic              exc_req,
  output logic [4:0]        exc_code,
  output logic              exc_in_delay
);
  localparam logic [IDX_W-1:0] I_STAT  = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] I_CAUSE = IDX_W'(IDX_CAUSE);
  localparam logic [IDX_W-1:0] I_EPC   = IDX_W'(IDX_EPC);

  logic wr_do, wr_stat, wr_cause, wr_epc, wr_arr, rfe_do, sys_do;
  logic sw_pend, sw_take, exc_take;
  logic [31:0] status_q, status_base, cause_q, cause_base, epc_q;
  logic [DATA_W-1:0] arr_rdata, spec_q;
  rd_src_e src_q;

  // priority: syscall, then register write, then return-from-exception
  assign sys_do   = sys_req;
  assign wr_do    = wr_en & ~sys_req;
  assign wr_stat  = wr_do & (wr_idx == I_STAT);
  assign wr_cause = wr_do & (wr_idx == I_CAUSE);
  assign wr_epc   = wr_do & (wr_idx == I_EPC);
  assign wr_arr   = wr_do & ~(wr_stat | wr_cause | wr_epc);
  assign rfe_do   = rfe_req & ~sys_req & ~wr_en;

  assign sw_pend  = (|(status_base[9:8] & cause_base[9:8])) & status_base[0];
  assign sw_take  = (wr_stat | wr_cause) & sw_pend;
  assign exc_take = sys_do | sw_take;

  sc_status_unit u_status (
    .clk        (clk),
    .rst        (rst),
    .wr_stat    (wr_stat),
    .wr_data    (wr_data),
    .rfe_do     (rfe_do),
    .exc_take   (exc_take),
    .status_q   (status_q),
    .status_base(status_base)
  );

  sc_cause_unit u_cause (
    .clk       (clk),
    .rst       (rst),
    .wr_cause  (wr_cause),
    .wr_epc    (wr_epc),
    .wr_data   (wr_data),
    .sys_do    (sys_do),
    .sw_take   (sw_take),
    .in_delay  (in_delay),
    .instr_pc  (instr_pc),
    .cause_q   (cause_q),
    .cause_base(cause_base),
    .epc_q     (epc_q)
  );

  sc_reg_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk  (clk),
    .we   (wr_arr),
    .waddr(wr_idx),
    .wdata(wr_data),
    .re   (rd_en),
    .raddr(rd_idx),
    .rdata(arr_rdata)
  );

  // read path: special registers captured alongside the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_ARRAY;
      spec_q <= '0;
    end else if (rd_en) begin
      unique case (rd_idx)
        I_STAT:  begin src_q <= SRC_STATUS; spec_q <= status_q; end
        I_CAUSE: begin src_q <= SRC_CAUSE;  spec_q <= cause_q;  end
        I_EPC:   begin src_q <= SRC_EPC;    spec_q <= epc_q;    end
        default: begin src_q <= SRC_ARRAY;  spec_q <= '0;       end
      endcase
    end
  end

  assign rd_data = (src_q == SRC_ARRAY) ? arr_rdata : spec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req      <= 1'b0;
      exc_code     <= '0;
      exc_in_delay <= 1'b0;
    end else begin
      exc_req <= exc_take;
      if (exc_take) begin
        exc_code     <= sys_do ? CODE_SYSCALL : CODE_INTR;
        exc_in_delay <= in_delay;
      end
    end
  end
endmodule

// File: rtl/sc_checker.sv
module sc_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic        rfe_req,
  input logic        sys_req,
  input logic [31:0] instr_pc,
  input logic        exc_req,
  input logic [4:0]  exc_code,
  input logic        exc_in_delay,
  input logic [31:0] status_q,
  input logic [31:0] cause_q,
  input logic [31:0] epc_q
);
  AST_CAUSE_WR_MASK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 5'd13 && !sys_req) |=>
      (cause_q[30:10] == $past(cause_q[30:10]) && cause_q[7] == $past(cause_q[7])
       && cause_q[1:0] == $past(cause_q[1:0]))); // R3

  AST_SWINT_STATE: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_code == 5'd0) |-> (cause_q[6:2] == 5'd0 && status_q[1:0] == 2'b00)); // R4

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(sys_req || (wr_en && (wr_idx == 5'd12 || wr_idx == 5'd13)))); // R5

  AST_RFE_POP: assert property (@(posedge clk) disable iff (rst)
    (rfe_req && !sys_req && !wr_en) |=>
      (status_q[3:0] == $past(status_q[5:2]) && status_q[31:4] == $past(status_q[31:4]))); // R6

  AST_SYSCALL_ENTRY: assert property (@(posedge clk) disable iff (rst)
    sys_req |=> (exc_req && exc_code == 5'd8 && cause_q[6:2] == 5'd8
                 && epc_q == $past(instr_pc))); // R7

  AST_DELAY_FLAG: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (cause_q[31] == exc_in_delay)); // R8

  AST_STACK_PUSH: assert property (@(posedge clk) disable iff (rst)
    sys_req |=> (status_q[5:2] == $past(status_q[3:0]) && status_q[1:0] == 2'b00
                 && status_q[31:6] == $past(status_q[31:6]))); // R9
endmodule

bind sysctrl_regs sc_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .rfe_req     (rfe_req),
  .sys_req     (sys_req),
  .instr_pc    (instr_pc),
  .exc_req     (exc_req),
  .exc_code    (exc_code),
  .exc_in_delay(exc_in_delay),
  .status_q    (status_q),
  .cause_q     (cause_q),
  .epc_q       (epc_q)
);

// File: tb/sim_sysctrl_regs.sv
module sim_sysctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, rfe_req, sys_req, in_delay;
  logic [4:0]  wr_idx, rd_idx;
  logic [31:0] wr_data, instr_pc, rd_data;
  logic        exc_req, exc_in_delay;
  logic [4:0]  exc_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctrl_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rfe_req(rfe_req),
    .sys_req(sys_req), .instr_pc(instr_pc), .in_delay(in_delay),
    .exc_req(exc_req), .exc_code(exc_code), .exc_in_delay(exc_in_delay)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; rfe_req = 0; sys_req = 0;
  endtask

  // one clock: drive at negedge, edge, back to negedge for sampling
  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic wr(input logic [4:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; step();
  endtask

  task automatic rd_chk(input string req, input logic [4:0] i, input logic [31:0] exp);
    rd_en = 1; rd_idx = i; step();
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    check("R1 exc_req", {31'd0, exc_req}, 32'd0);
    rd_chk("R1 status", 5'd12, 32'd0);
    rd_chk("R1 cause", 5'd13, 32'd0);
    rd_chk("R1 epc", 5'd14, 32'd0);
  endtask

  task automatic t_gpr();
    wr(5'd3, 32'hDEADBEEF);
    wr(5'd31, 32'h12345678);
    wr(5'd14, 32'hCAFE0004);
    rd_chk("R2 idx3", 5'd3, 32'hDEADBEEF);
    rd_chk("R2 idx31", 5'd31, 32'h12345678);
    rd_chk("R2 epc", 5'd14, 32'hCAFE0004);
  endtask

  task automatic t_read_first();
    wr(5'd5, 32'h11);
    wr_en = 1; wr_idx = 5'd5; wr_data = 32'h22; rd_en = 1; rd_idx = 5'd5; step();
    check("R10 old value", rd_data, 32'h11);
    rd_chk("R10 new value", 5'd5, 32'h22);
  endtask

  task automatic t_cause_mask();
    wr(5'd12, 32'h0);
    wr(5'd13, 32'hFFFFFFFF);
    check("R3 no exc without enable", {31'd0, exc_req}, 32'd0);
    rd_chk("R3 cause masked", 5'd13, 32'h00000300);
  endtask

  task automatic t_swint_status();
    instr_pc = 32'h80000040; in_delay = 1;
    wr(5'd12, 32'h00000101);
    check("R4 exc_req", {31'd0, exc_req}, 32'd1);
    check("R4 code", {27'd0, exc_code}, 32'd0);
    check("R8 delay out", {31'd0, exc_in_delay}, 32'd1);
    in_delay = 0;
    step();
    check("R4 pulse ends", {31'd0, exc_req}, 32'd0);
    rd_chk("R9 status push", 5'd12, 32'h00000104);
    rd_chk("R8 cause", 5'd13, 32'h80000300);
    rd_chk("R4 epc", 5'd14, 32'h80000040);
  endtask

  task automatic t_rfe_nocheck();
    rfe_req = 1; step();
    check("R5 no exc on rfe", {31'd0, exc_req}, 32'd0);
    step();
    check("R5 still none", {31'd0, exc_req}, 32'd0);
    rd_chk("R6 pop", 5'd12, 32'h00000101);
    wr(5'd13, 32'h0);
    check("R4 no pending", {31'd0, exc_req}, 32'd0);
    rd_chk("R3 bit31 kept", 5'd13, 32'h80000000);
  endtask

  task automatic t_syscall();
    instr_pc = 32'h00001000; in_delay = 0;
    sys_req = 1; step();
    check("R7 exc_req", {31'd0, exc_req}, 32'd1);
    check("R7 code", {27'd0, exc_code}, 32'd8);
    check("R8 delay out", {31'd0, exc_in_delay}, 32'd0);
    rd_chk("R9 push", 5'd12, 32'h00000104);
    rd_chk("R7 cause", 5'd13, 32'h00000020);
    rd_chk("R7 epc", 5'd14, 32'h00001000);
  endtask

  task automatic t_priority();
    instr_pc = 32'h00002000;
    sys_req = 1; wr_en = 1; wr_idx = 5'd12; wr_data = 32'h0000FFFF; step();
    check("R11 sys taken", {27'd0, exc_code}, 32'd8);
    rd_chk("R11 write ignored", 5'd12, 32'h00000110);
    wr(5'd20, 32'h0);
    wr_en = 1; wr_idx = 5'd21; wr_data = 32'hA5; rfe_req = 1; step();
    rd_chk("R11 rfe ignored", 5'd12, 32'h00000110);
    rfe_req = 1; step();
    rd_chk("R6 pop", 5'd12, 32'h00000114);
  endtask

  task automatic t_swint_cause();
    instr_pc = 32'h00003000; in_delay = 0;
    wr(5'd12, 32'h00000201);
    check("R4 no exc yet", {31'd0, exc_req}, 32'd0);
    wr(5'd13, 32'h00000200);
    check("R4 exc on cause write", {31'd0, exc_req}, 32'd1);
    check("R4 code", {27'd0, exc_code}, 32'd0);
    rd_chk("R4 cause code cleared", 5'd13, 32'h00000200);
    rd_chk("R9 push", 5'd12, 32'h00000204);
    rd_chk("R4 epc", 5'd14, 32'h00003000);
  endtask

  initial begin
    idle(); wr_idx = 0; rd_idx = 0; wr_data = 0; instr_pc = 0; in_delay = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_gpr();
    t_read_first();
    t_cause_mask();
    t_swint_status();
    t_rfe_nocheck();
    t_syscall();
    t_priority();
    t_swint_cause();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule